// File: doc/BRIEF.md
# Dual-Energy Line Acquisition Sequencer

This block times the capture of one detector line from a linear X-ray front end that carries two energy planes. Each line period runs three phases: the charge integrators are first held in reset, then left to integrate, then read out. During readout an analog multiplexer walks every channel of the low-energy plane and then every channel of the high-energy plane. For each channel the block fires a convert strobe at a serial 16-bit SAR converter and clocks the result in over a three-wire link (convert, serial clock, serial data).

Every finished conversion leaves the block as one pixel on a valid/data stream. Start-of-line and end-of-line flags mark the first and last pixel of the line. A gain code for the integrators is taken at the start of each line and held for the whole line. An enable input gates line generation. When enable drops, the block finishes the line it is in and then parks in idle with the integrators in reset.

State machine: `ST_IDLE` (integrators in reset, waiting) goes to `ST_RESET` when enable is high. `ST_RESET` goes to `ST_INTEG` after `RST_CYC` cycles. `ST_INTEG` goes to `ST_READ` after `INT_CYC` cycles. `ST_READ` runs one slot of `SLOT_CYC` cycles per pixel. After the last slot it returns to `ST_RESET` if enable is high, otherwise to `ST_IDLE`. The gain code is captured on every transition into `ST_RESET`.

Top module: `line_acq_seq`

## Requirements
- R1: `int_rst` is high in idle and for exactly `RST_CYC` cycles at the start of each line. It is followed at once by exactly `INT_CYC` cycles with `integ` high. The two are never high together, and both are low during readout.
- R2: While `en` stays high, consecutive `pix_sol` pulses are spaced exactly `RST_CYC + INT_CYC + 2*CH*SLOT_CYC` cycles apart.
- R3: Each readout slot carries one `adc_cnv` pulse exactly `CNV_CYC` cycles wide. It is followed by exactly `SMP_W` rising edges of `adc_sclk`, and `adc_sclk` is never high while `adc_cnv` is high.
- R4: Serial data is captured on each rising edge of `adc_sclk`, MSB first. The captured word appears on `pix_data` unchanged.
- R5: Pixel index p of a line (0 to 2*CH-1) selects plane `mux_he = (p >= CH)` (0 = low energy, 1 = high energy) and channel `mux_ch = p mod CH`. The selection is stable while the convert pulse for that pixel is high, so the line holds low-energy channels 0..CH-1 followed by high-energy channels 0..CH-1.
- R6: Each line has exactly 2*CH cycles with `pix_valid` high. `pix_sol` is high only with pixel 0 and `pix_eol` only with pixel 2*CH-1, and neither is ever high without `pix_valid`.
- R7: One pixel is emitted per conversion. Within a line, successive `pix_valid` pulses are `SLOT_CYC` cycles apart, and `pix_valid` is never high with `adc_cnv`.
- R8: `gain_out` takes the value of `gain_in` on the transition into the reset phase. It changes at no other time, so a change of `gain_in` during a line takes effect only on the next line.
- R9: After `en` falls mid-line, the current line completes with all its pixels. No further convert pulse or pixel follows, `int_rst` stays high and `integ` stays low.
- R10: While `rst_n` is low: `int_rst` = 1; `integ`, `adc_cnv`, `adc_sclk` and `pix_valid` = 0; `gain_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Line generation enable |
| gain_in | input | GAIN_W | Integrator gain code, captured per line |
| int_rst | output | 1 | Integrator reset |
| integ | output | 1 | Integrate phase |
| gain_out | output | GAIN_W | Gain code held for the current line |
| mux_ch | output | $clog2(CH) | Multiplexer channel select |
| mux_he | output | 1 | Plane select, 1 = high energy |
| adc_cnv | output | 1 | Converter start strobe |
| adc_sclk | output | 1 | Converter serial clock |
| adc_sdo | input | 1 | Converter serial data |
| pix_valid | output | 1 | Pixel valid |
| pix_data | output | SMP_W | Pixel sample |
| pix_sol | output | 1 | First pixel of line |
| pix_eol | output | 1 | Last pixel of line |

## Verification
The assertions take for granted that `SLOT_CYC` leaves at least one cycle after the last serial bit, and that the converter model changes `adc_sdo` only away from the sampling edge. The bench model updates data on the falling clock, after each observed convert fall and serial clock rise. The bench changes `en` and `gain_in` only on falling clock edges and at chosen points mid-line, so the per-line capture and the finish-the-line behaviour are exercised without racing the sampling edge. A small configuration (4 channels per plane) lets every pixel of four full lines be compared against an arithmetic code built from line number, plane and channel.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESET,
        ST_INTEG,
        ST_READ
    } acq_state_e;
endpackage

// File: rtl/acq_line_fsm.sv
module acq_line_fsm
    import acq_seq_pkg::*;
#(
    parameter int CH      = 64,
    parameter int RST_CYC = 1000,
    parameter int INT_CYC = 108000,
    parameter int GAIN_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          slot_done,
    input  logic [GAIN_W-1:0]             gain_in,
    output acq_state_e                    state,
    output logic [$clog2(2*CH)-1:0]       pix_idx,
    output logic [GAIN_W-1:0]             gain_q
);
    localparam int NPIX  = 2 * CH;
    localparam int IDX_W = $clog2(NPIX);
    localparam int PH_MX = (RST_CYC > INT_CYC) ? RST_CYC : INT_CYC;
    localparam int PH_W  = $clog2(PH_MX + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

    acq_state_e        st_nxt;
    logic [PH_W-1:0]   ph_cnt;

    always_comb begin
        st_nxt = state;
        unique case (state)
            ST_IDLE:  if (en) st_nxt = ST_RESET;
            ST_RESET: if (ph_cnt == PH_W'(RST_CYC - 1)) st_nxt = ST_INTEG;
            ST_INTEG: if (ph_cnt == PH_W'(INT_CYC - 1)) st_nxt = ST_READ;
            ST_READ:  if (slot_done && pix_idx == LAST_IDX)
                          st_nxt = en ? ST_RESET : ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt  <= '0;
            pix_idx <= '0;
            gain_q  <= '0;
        end else begin
            ph_cnt <= (st_nxt != state) ? '0 : ph_cnt + 1'b1;
            if (state != ST_READ)
                pix_idx <= '0;
            else if (slot_done)
                pix_idx <= (pix_idx == LAST_IDX) ? '0 : pix_idx + 1'b1;
            if (st_nxt == ST_RESET && state != ST_RESET)
                gain_q <= gain_in;
        end
    end
endmodule

// File: rtl/acq_adc_reader.sv
module acq_adc_reader #(
    parameter int SMP_W    = 16,
    parameter int CNV_CYC  = 88,
    parameter int SLOT_CYC = 125
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             sdo,
    output logic             cnv,
    output logic             sclk,
    output logic             slot_done,
    output logic             word_valid,
    output logic [SMP_W-1:0] word
);
    localparam int CW     = $clog2(SLOT_CYC);
    localparam int BIT_LO = CNV_CYC;
    localparam int BIT_HI = CNV_CYC + 2 * SMP_W;

    logic [CW-1:0] scnt;
    logic          in_win;
    logic          rise_slot;
    logic [CW-1:0] rel;

    always_comb begin
        rel       = scnt - CW'(BIT_LO);
        in_win    = (scnt >= CW'(BIT_LO)) && (scnt < CW'(BIT_HI));
        rise_slot = in_win && rel[0];
        slot_done = active && (scnt == CW'(SLOT_CYC - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt       <= '0;
            cnv        <= 1'b0;
            sclk       <= 1'b0;
            word_valid <= 1'b0;
            word       <= '0;
        end else if (!active) begin
            scnt       <= '0;
            cnv        <= 1'b0;
            sclk       <= 1'b0;
            word_valid <= 1'b0;
        end else begin
            scnt       <= (scnt == CW'(SLOT_CYC - 1)) ? '0 : scnt + 1'b1;
            cnv        <= (scnt < CW'(CNV_CYC));
            sclk       <= rise_slot;
            word_valid <= (scnt == CW'(BIT_HI - 1));
            if (rise_slot)
                word <= {word[SMP_W-2:0], sdo};
        end
    end
endmodule

// File: rtl/line_acq_seq.sv
module line_acq_seq
    import acq_seq_pkg::*;
#(
    parameter int CH       = 64,
    parameter int SMP_W    = 16,
    parameter int RST_CYC  = 1000,
    parameter int INT_CYC  = 108000,
    parameter int CNV_CYC  = 88,
    parameter int SLOT_CYC = 125,
    parameter int GAIN_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [GAIN_W-1:0]       gain_in,
    output logic                    int_rst,
    output logic                    integ,
    output logic [GAIN_W-1:0]       gain_out,
    output logic [$clog2(CH)-1:0]   mux_ch,
    output logic                    mux_he,
    output logic                    adc_cnv,
    output logic                    adc_sclk,
    input  logic                    adc_sdo,
    output logic                    pix_valid,
    output logic [SMP_W-1:0]        pix_data,
    output logic                    pix_sol,
    output logic                    pix_eol
);
    localparam int NPIX  = 2 * CH;
    localparam int IDX_W = $clog2(NPIX);
    localparam int CH_W  = $clog2(CH);

    acq_state_e        state;
    logic [IDX_W-1:0]  pix_idx;
    logic              slot_done;
    logic              rd_active;

    acq_line_fsm #(
        .CH(CH), .RST_CYC(RST_CYC), .INT_CYC(INT_CYC), .GAIN_W(GAIN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .slot_done(slot_done),
        .gain_in(gain_in), .state(state), .pix_idx(pix_idx), .gain_q(gain_out)
    );

    assign rd_active = (state == ST_READ);

    acq_adc_reader #(
        .SMP_W(SMP_W), .CNV_CYC(CNV_CYC), .SLOT_CYC(SLOT_CYC)
    ) u_adc (
        .clk(clk), .rst_n(rst_n), .active(rd_active), .sdo(adc_sdo),
        .cnv(adc_cnv), .sclk(adc_sclk), .slot_done(slot_done),
        .word_valid(pix_valid), .word(pix_data)
    );

    always_comb begin
        int_rst = 1'b0;
        integ   = 1'b0;
        unique case (state)
            ST_IDLE:  int_rst = 1'b1;
            ST_RESET: int_rst = 1'b1;
            ST_INTEG: integ   = 1'b1;
            ST_READ:  ;
            default:  int_rst = 1'b1;
        endcase
    end

    always_comb begin
        mux_he  = (pix_idx >= IDX_W'(CH));
        mux_ch  = CH_W'(mux_he ? (pix_idx - IDX_W'(CH)) : pix_idx);
        pix_sol = pix_valid && (pix_idx == '0);
        pix_eol = pix_valid && (pix_idx == IDX_W'(NPIX - 1));
    end
endmodule

// File: rtl/acq_seq_checker.sv
module acq_seq_checker #(
    parameter int GAIN_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_rst,
    input logic              integ,
    input logic [GAIN_W-1:0] gain_out,
    input logic              adc_cnv,
    input logic              adc_sclk,
    input logic              pix_valid,
    input logic              pix_sol,
    input logic              pix_eol
);
    // R1: reset and integrate phases are exclusive
    assert_phase_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_rst && integ));

    // R1: integration always follows the reset phase
    assert_integ_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(integ) |-> $past(int_rst));

    // R3: serial clock never overlaps convert
    assert_sclk_not_cnv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk |-> !adc_cnv);

    // R6: line markers only with valid
    assert_sol_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sol |-> pix_valid);
    assert_eol_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eol |-> pix_valid);

    // R7: a pixel never coincides with a convert strobe
    assert_valid_not_cnv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !adc_cnv);

    // R8: gain changes only while the integrator is reset
    assert_gain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_out) |-> int_rst);

    // R9: no conversion activity outside readout
    assert_quiet_outside_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rst || integ) |-> (!adc_cnv && !adc_sclk && !pix_valid));
endmodule

bind line_acq_seq acq_seq_checker #(.GAIN_W(GAIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .int_rst(int_rst), .integ(integ),
    .gain_out(gain_out), .adc_cnv(adc_cnv), .adc_sclk(adc_sclk),
    .pix_valid(pix_valid), .pix_sol(pix_sol), .pix_eol(pix_eol)
);

// File: tb/tb_line_acq_seq.sv
module tb_line_acq_seq;
    localparam int CH       = 4;
    localparam int SMP_W    = 16;
    localparam int RST_CYC  = 3;
    localparam int INT_CYC  = 5;
    localparam int CNV_CYC  = 4;
    localparam int SLOT_CYC = 40;
    localparam int GAIN_W   = 2;
    localparam int NPIX     = 2 * CH;
    localparam int LINE_PER = RST_CYC + INT_CYC + NPIX * SLOT_CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [GAIN_W-1:0] gain_in = 2'd1;
    logic int_rst, integ, mux_he, adc_cnv, adc_sclk;
    logic adc_sdo = 1'b0;
    logic pix_valid, pix_sol, pix_eol;
    logic [GAIN_W-1:0] gain_out;
    logic [$clog2(CH)-1:0] mux_ch;
    logic [SMP_W-1:0] pix_data;

    always #4 clk = ~clk;

    line_acq_seq #(
        .CH(CH), .SMP_W(SMP_W), .RST_CYC(RST_CYC), .INT_CYC(INT_CYC),
        .CNV_CYC(CNV_CYC), .SLOT_CYC(SLOT_CYC), .GAIN_W(GAIN_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .gain_in(gain_in),
        .int_rst(int_rst), .integ(integ), .gain_out(gain_out),
        .mux_ch(mux_ch), .mux_he(mux_he), .adc_cnv(adc_cnv),
        .adc_sclk(adc_sclk), .adc_sdo(adc_sdo), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_sol(pix_sol), .pix_eol(pix_eol)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [15:0] code_of(int ln, logic he, int ch);
        int v;
        v = (ln * 4951) ^ (ch * 1093) ^ (he ? 32'hA5C3 : 32'h0) ^ 32'h8001;
        return v[15:0];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int cyc = 0, mline = 0, lines = 0, pidx = 0, total_pix = 0;
    int integ_run = 0, rst_run = 0, cnv_run = 0, sclk_rises = 0;
    int last_sol = 0, last_valid = 0, cnv_after_end = 0;
    logic [15:0] word = '0;
    logic p_integ = 0, p_cnv = 0, p_sclk = 0, p_rst = 1;
    bit rst_checked = 0, final_chk = 0, final_done = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            if (!rst_checked) begin
                chk(int_rst == 1'b1, "R10 int_rst", int'(int_rst), 1);
                chk({integ, adc_cnv, adc_sclk, pix_valid} == 4'b0, "R10 outputs idle",
                    int'({integ, adc_cnv, adc_sclk, pix_valid}), 0);
                chk(gain_out == '0, "R10 gain_out", int'(gain_out), 0);
                rst_checked = 1;
            end
        end else begin
            // converter model driven from the mux selection
            if (integ && !p_integ) mline++;
            if (adc_cnv && !p_cnv) word = code_of(mline, mux_he, int'(mux_ch));
            if (!adc_cnv && p_cnv) adc_sdo = word[15];
            if (adc_sclk && !p_sclk) begin
                word = word << 1;
                adc_sdo = word[15];
                sclk_rises++;
            end
            // R1 phase lengths
            if (integ) integ_run++;
            if (!integ && p_integ) begin
                chk(integ_run == INT_CYC, "R1 integrate length", integ_run, INT_CYC);
                integ_run = 0;
            end
            if (int_rst) rst_run++;
            if (!int_rst && p_rst) begin
                if (lines > 0) chk(rst_run == RST_CYC, "R1 reset length", rst_run, RST_CYC);
                rst_run = 0;
            end
            // R3 convert pulse, R5 mux selection
            if (adc_cnv) begin
                if (!p_cnv) begin
                    chk(mux_he == (pidx >= CH), "R5 plane select", int'(mux_he), int'(pidx >= CH));
                    chk(int'(mux_ch) == pidx % CH, "R5 channel select", int'(mux_ch), pidx % CH);
                    if (total_pix >= 4 * NPIX) cnv_after_end++;
                end
                cnv_run++;
            end
            if (!adc_cnv && p_cnv) begin
                chk(cnv_run == CNV_CYC, "R3 convert width", cnv_run, CNV_CYC);
                cnv_run = 0;
                sclk_rises = 0;
            end
            // pixel stream
            if (pix_valid) begin
                chk(pix_sol == (pidx == 0), "R6 start marker", int'(pix_sol), int'(pidx == 0));
                chk(pix_eol == (pidx == NPIX - 1), "R6 end marker", int'(pix_eol), int'(pidx == NPIX - 1));
                if (pidx == 0) begin
                    if (lines > 0) chk(cyc - last_sol == LINE_PER, "R2 line period", cyc - last_sol, LINE_PER);
                    lines++;
                    last_sol = cyc;
                end else begin
                    chk(cyc - last_valid == SLOT_CYC, "R7 pixel spacing", cyc - last_valid, SLOT_CYC);
                end
                chk(sclk_rises == SMP_W, "R3 serial clock count", sclk_rises, SMP_W);
                chk(pix_data == code_of(lines, pidx >= CH, pidx % CH), "R4 pixel data",
                    int'(pix_data), int'(code_of(lines, pidx >= CH, pidx % CH)));
                chk(int'(gain_out) == ((lines <= 2) ? 1 : 2), "R8 gain per line",
                    int'(gain_out), (lines <= 2) ? 1 : 2);
                last_valid = cyc;
                total_pix++;
                pidx = (pidx == NPIX - 1) ? 0 : pidx + 1;
            end
            if (final_chk && !final_done) begin
                chk(total_pix == 4 * NPIX, "R9 pixels after stop", total_pix, 4 * NPIX);
                chk(lines == 4, "R6 line count", lines, 4);
                chk(cnv_after_end == 0, "R9 no convert after stop", cnv_after_end, 0);
                chk(int_rst == 1'b1 && integ == 1'b0, "R9 idle phase",
                    int'({int_rst, integ}), 2);
                final_done = 1;
            end
        end
        p_integ = integ;
        p_cnv = adc_cnv;
        p_sclk = adc_sclk;
        p_rst = int_rst;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (7) @(negedge clk);
        en = 1'b1;
        wait (lines == 2 && pidx == 3);
        @(negedge clk);
        gain_in = 2'd2;
        wait (lines == 4 && pidx == 2);
        @(negedge clk);
        en = 1'b0;
        repeat (3 * LINE_PER) @(negedge clk);
        final_chk = 1;
        wait (final_done);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end
endmodule